// File: doc/BRIEF.md
# Eight-Input Programmable Priority Interrupt Controller

This block gathers eight edge-triggered interrupt request lines and presents the most urgent one to a processor. Software programs it through a byte-wide port with two addresses, chosen by a single address bit. A short sequence of setup words sets the vector base, the cascade pattern and the end-of-interrupt style. Once the sequence is finished, the odd address holds the mask register and the even address takes commands.

Each request is latched on its rising edge. A request is raised to the processor when it is unmasked and outranks every level already in service, with input 0 the most urgent. The processor takes a request with a one-cycle acknowledge pulse. The controller replies with an 8-bit vector, which is the programmed base plus the input number, and marks that level in service. Software later releases the level with a non-specific or specific end-of-interrupt command, unless automatic release was chosen at setup. If an acknowledge arrives and no valid request exists, the reply is the vector for input 7 and no level is marked.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, `ready` is low, `int_req` is low, `vector` is 0x00 and the even-address read returns the request register.
- R2: An even-address write with data bit 4 set starts setup. Bit 1 of that word set means single mode, so no cascade word follows. Bit 0 set means a fourth word follows. The next odd-address write is the vector base. `ready` rises after the last expected word, and `int_req` stays low while `ready` is low.
- R3: The third setup word, when present, is stored unchanged and driven on `cascade_cfg`. On a master it is the slave-present bitmask; on a slave it is the identity.
- R4: Bit 1 of the fourth setup word selects automatic end-of-interrupt. When the fourth word is skipped, normal end-of-interrupt applies.
- R5: While `ready` is high, or before any setup, an odd-address write loads the mask and an odd-address read returns it. A set mask bit keeps that input from raising `int_req`.
- R6: A request bit is set by a rising edge on its input, stays set while the input is high, and clears when the input falls or the level is acknowledged. A held-high input needs a new rising edge to request again.
- R7: Fixed priority: the lowest-numbered pending unmasked input wins. It is presented only if no in-service level is numbered equal to or lower than it.
- R8: An acknowledge while `int_req` is high returns base plus the winning input number on `vector` in the next cycle. It sets exactly that in-service bit and clears that request bit.
- R9: An acknowledge while `int_req` is low returns base plus 7 and changes no in-service bit, even when input 7 is masked.
- R10: An even-address write with bits 7:5 = 001 and bits 4:3 = 00 (for example 0x20) clears the lowest-numbered in-service bit.
- R11: An even-address write with bits 7:5 = 011 and bits 4:3 = 00 clears only the in-service bit named by bits 2:0 (0x60 plus the level).
- R12: An even-address write with bits 4:3 = 01 and bit 1 set selects the in-service register for even-address reads if bit 0 is 1, and the request register if bit 0 is 0 (0x0B and 0x0A). The choice persists until it is changed.
- R13: In automatic end-of-interrupt mode, an acknowledge returns the vector but leaves no in-service bit set.
- R14: The first setup word clears the in-service register and selects the request register for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| a0 | input | 1 | Register address select, 0 even, 1 odd |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the address on `a0` |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | One-cycle acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector returned by the last acknowledge |
| ready | output | 1 | Setup sequence completed |
| cascade_cfg | output | 8 | Stored cascade setup word |

## Verification
The bench sweeps all 255 non-empty request patterns. For each it checks that the lowest set bit is vectored and that the remaining lower-priority inputs are blocked while it is in service. A priority encoder scanning the wrong way, or one ignoring the in-service register, would return the wrong vector or raise a second request. Nesting is driven in both directions: a higher level must break through and a lower level must wait. Both end-of-interrupt forms are then used to release the nest; a wrong clear would leave a stale in-service bit that silences later requests. The bench also covers an acknowledge with no request behind it, an input held high after its acknowledge, automatic release, and setup sequences with the optional words skipped. A design that set in-service on a spurious acknowledge, re-requested without an edge, or waited for a word that was never sent would show it in those checks.

// File: rtl/pic_pkg.sv
// Package: shared types for the interrupt controller.
// Assumes: one setup sequence in flight at a time.
package pic_pkg;
    // Setup sequencer states
    typedef enum logic [2:0] {
        ST_UNSET = 3'd0,
        ST_BASE  = 3'd1,
        ST_CASC  = 3'd2,
        ST_MODE  = 3'd3,
        ST_RUN   = 3'd4
    } setup_st_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/pic_prio_enc.sv
// Module: pic_prio_enc
// Finds the lowest-numbered set bit of a request vector (bit 0 most urgent).
// Assumes: purely combinational; idx is 0 when nothing is set.
module pic_prio_enc #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from least to most urgent so the most urgent hit is kept last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
// Module: pic_req_latch
// Edge-triggered request register: a bit sets on a rising input and is
// kept while the input stays high; it drops on a falling input or when
// its level is granted.
// Assumes: inputs already synchronous to clk.
module pic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] grant_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;

    // Remember the previous input sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    // Capture rising edges, drop on a low input or on a grant
    always_ff @(posedge clk) begin
        if (!rst_n) irr <= '0;
        else        irr <= (irr | (irq_in & ~prev_q)) & irq_in & ~grant_clr;
    end
endmodule

// File: rtl/pic_cmd_decode.sv
// Module: pic_cmd_decode
// Decodes the byte-wide register port: runs the setup word sequence,
// holds base, cascade word, release mode, mask and read select, and
// emits one-cycle end-of-interrupt strobes.
// Assumes: wr_en is a single-cycle strobe per byte.
module pic_cmd_decode
    import pic_pkg::*;
#(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              a0,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              ready,
    output logic [BYTE_W-1:0] vec_base,
    output logic [BYTE_W-1:0] casc_word,
    output logic              auto_rel,
    output logic [N-1:0]      mask,
    output logic              sel_isr,
    output logic              setup_start,
    output logic              eoi_any,
    output logic              eoi_lvl,
    output logic [IDX_W-1:0]  eoi_num
);
    setup_st_t st_q;
    logic      single_q;
    logic      want_mode_q;
    logic      cmd_wr;

    assign ready       = (st_q == ST_RUN);
    assign setup_start = wr_en && !a0 && wr_data[4];
    assign cmd_wr      = wr_en && !a0 && ready && (wr_data[4:3] == 2'b00);
    assign eoi_any     = cmd_wr && (wr_data[7:5] == 3'b001);
    assign eoi_lvl     = cmd_wr && (wr_data[7:5] == 3'b011);
    assign eoi_num     = wr_data[IDX_W-1:0];

    // Sequence the setup words and hold the programmed configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_UNSET;
            single_q    <= 1'b0;
            want_mode_q <= 1'b0;
            vec_base    <= '0;
            casc_word   <= '0;
            auto_rel    <= 1'b0;
            mask        <= '1;
            sel_isr     <= 1'b0;
        end else if (setup_start) begin
            st_q        <= ST_BASE;
            single_q    <= wr_data[1];
            want_mode_q <= wr_data[0];
            auto_rel    <= 1'b0;
            sel_isr     <= 1'b0;
        end else if (wr_en) begin
            case (st_q)
                ST_BASE: if (a0) begin
                    vec_base <= wr_data;
                    if (!single_q)       st_q <= ST_CASC;
                    else if (want_mode_q) st_q <= ST_MODE;
                    else                 st_q <= ST_RUN;
                end
                ST_CASC: if (a0) begin
                    casc_word <= wr_data;
                    st_q      <= want_mode_q ? ST_MODE : ST_RUN;
                end
                ST_MODE: if (a0) begin
                    auto_rel <= wr_data[1];
                    st_q     <= ST_RUN;
                end
                ST_RUN: begin
                    if (a0) mask <= wr_data[N-1:0];
                    else if (wr_data[4:3] == 2'b01 && wr_data[1]) sel_isr <= wr_data[0];
                end
                default: if (a0) mask <= wr_data[N-1:0];
            endcase
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
// Module: pic_ctrl (top)
// Eight-input priority interrupt controller: request latch, fixed
// priority against the in-service set, acknowledge with vector, and
// end-of-interrupt handling.
// Assumes: ack is a one-cycle pulse; the vector is valid the cycle after.
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int SPUR  = N - 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        a0,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic [7:0]  irq_in,
    input  logic        ack,
    output logic        int_req,
    output logic [7:0]  vector,
    output logic        ready,
    output logic [7:0]  cascade_cfg
);
    logic [BYTE_W-1:0] vec_base;
    logic              auto_rel, sel_isr, setup_start;
    logic              eoi_any, eoi_lvl;
    logic [IDX_W-1:0]  eoi_num;
    logic [N-1:0]      mask, irr, isr, pend, grant_vec, eoi_clr;
    logic              p_found, s_found, grant;
    logic [IDX_W-1:0]  p_idx, s_idx;

    pic_cmd_decode #(.N(N)) i_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wr_data(wr_data),
        .ready(ready), .vec_base(vec_base), .casc_word(cascade_cfg),
        .auto_rel(auto_rel), .mask(mask), .sel_isr(sel_isr),
        .setup_start(setup_start), .eoi_any(eoi_any), .eoi_lvl(eoi_lvl),
        .eoi_num(eoi_num)
    );

    pic_req_latch #(.N(N)) i_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in[N-1:0]),
        .grant_clr(grant_vec), .irr(irr)
    );

    assign pend = irr & ~mask;

    pic_prio_enc #(.N(N)) i_pend_enc (.req(pend), .found(p_found), .idx(p_idx));
    pic_prio_enc #(.N(N)) i_isr_enc  (.req(isr),  .found(s_found), .idx(s_idx));

    // Present a request only if it beats every level in service
    assign int_req = ready && p_found && (!s_found || (p_idx < s_idx));
    assign grant   = ack && int_req;

    // One-hot grant and end-of-interrupt clear vectors
    always_comb begin
        grant_vec = '0;
        eoi_clr   = '0;
        if (grant)                grant_vec[p_idx]   = 1'b1;
        if (eoi_any && s_found)   eoi_clr[s_idx]     = 1'b1;
        else if (eoi_lvl)         eoi_clr[eoi_num]   = 1'b1;
    end

    // In-service register: set on grant unless auto release, clear on EOI
    always_ff @(posedge clk) begin
        if (!rst_n)           isr <= '0;
        else if (setup_start) isr <= '0;
        else                  isr <= (isr & ~eoi_clr) | (auto_rel ? '0 : grant_vec);
    end

    // Latch the vector answered on each acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)     vector <= '0;
        else if (grant) vector <= vec_base + BYTE_W'(p_idx);
        else if (ack)   vector <= vec_base + BYTE_W'(SPUR);
    end

    // Read mux: odd address returns the mask, even the selected register
    always_comb begin
        rd_data = '0;
        if (a0)           rd_data[N-1:0] = mask;
        else if (sel_isr) rd_data[N-1:0] = isr;
        else              rd_data[N-1:0] = irr;
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
// Module: pic_ctrl_chk
// Temporal checks on the controller, attached to every pic_ctrl by bind.
// Assumes: synchronous active-low reset.
module pic_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ack,
    input logic         int_req,
    input logic [7:0]   vector,
    input logic [7:0]   vec_base,
    input logic         auto_rel,
    input logic [N-1:0] isr,
    input logic [N-1:0] irr,
    input logic [N-1:0] mask
);
    AST_ISR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((isr & ~$past(isr)) != '0)) |-> $past(ack));   // R8
    AST_ISR_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(isr & ~$past(isr)) <= 1));          // R8
    AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack) && !$past(int_req))
        |-> (vector == $past(vec_base) + 8'd7));                           // R9
    AST_AUTO_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(auto_rel)) |-> ((isr & ~$past(isr)) == '0)); // R13
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((irr & ~mask) != '0));                                // R5
endmodule

bind pic_ctrl pic_ctrl_chk #(.N(N)) i_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .int_req(int_req), .vector(vector),
    .vec_base(vec_base), .auto_rel(auto_rel), .isr(isr), .irr(irr), .mask(mask)
);

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       a0 = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] irq_in = '0;
    logic       ack = 1'b0;
    logic       int_req;
    logic [7:0] vector;
    logic       ready;
    logic [7:0] cascade_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_ctrl i_pic_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wr_data(wr_data),
        .rd_data(rd_data), .irq_in(irq_in), .ack(ack), .int_req(int_req),
        .vector(vector), .ready(ready), .cascade_cfg(cascade_cfg)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; a0 = addr; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic rd_sel(input bit want_isr, output logic [7:0] v);
        wr(1'b0, want_isr ? 8'h0B : 8'h0A);
        a0 = 1'b0; #1; v = rd_data;
    endtask

    task automatic rd_mask(output logic [7:0] v);
        @(negedge clk); a0 = 1'b1; #1; v = rd_data;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    function automatic int low_bit(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) low_bit = i;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        a0 = 1'b1; #1;
        check("R1 mask", rd_data, 8'hFF);
        check("R1 ready", {7'b0, ready}, 8'h00);
        check("R1 int_req", {7'b0, int_req}, 8'h00);
        check("R1 vector", vector, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R5: mask load before setup
        wr(1'b1, 8'h00);
        rd_mask(v); check("R5 mask pre-setup", v, 8'h00);
        set_irq(8'h01);
        check("R2 no int before ready", {7'b0, int_req}, 8'h00);
        set_irq(8'h00);

        // R2/R3/R4: full four-word setup
        wr(1'b0, 8'h11);
        check("R2 not ready mid", {7'b0, ready}, 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        check("R2 waits mode word", {7'b0, ready}, 8'h00);
        wr(1'b1, 8'h01);
        check("R2 ready", {7'b0, ready}, 8'h01);
        check("R3 cascade", cascade_cfg, 8'h04);

        // R7/R8/R10: sweep of every request pattern
        for (int p = 1; p < 256; p++) begin
            set_irq(8'(p));
            check("R7 int raised", {7'b0, int_req}, 8'h01);
            pulse_ack();
            check("R8 vector", vector, 8'h20 + 8'(low_bit(8'(p))));
            check("R7 lower blocked", {7'b0, int_req}, 8'h00);
            wr(1'b0, 8'h20);
            irq_in = 8'h00; @(negedge clk);
        end
        rd_sel(1'b1, v); check("R10 ISR empty after sweep", v, 8'h00);

        // R8/R12: in-service readback and persistent select
        set_irq(8'h20);
        pulse_ack();
        rd_sel(1'b1, v); check("R8 ISR bit5", v, 8'h20);
        @(negedge clk); #1; check("R12 select persists", rd_data, 8'h20);
        // R7: higher level breaks through, lower waits
        set_irq(8'h64);
        check("R7 nest higher", {7'b0, int_req}, 8'h01);
        pulse_ack();
        check("R8 nest vector", vector, 8'h22);
        a0 = 1'b0; #1; check("R8 ISR nest", rd_data, 8'h24);
        rd_sel(1'b0, v); check("R12 IRR select", v, 8'h40);
        check("R7 lower waits", {7'b0, int_req}, 8'h00);
        wr(1'b0, 8'h20);
        rd_sel(1'b1, v); check("R10 clears top", v, 8'h20);
        wr(1'b0, 8'h65);
        rd_sel(1'b1, v); check("R11 specific", v, 8'h00);
        check("R7 released", {7'b0, int_req}, 8'h01);
        pulse_ack();
        check("R8 level6", vector, 8'h26);
        wr(1'b0, 8'h63);
        rd_sel(1'b1, v); check("R11 other level kept", v, 8'h40);
        wr(1'b0, 8'h66);

        // R6: held input does not re-request; new edge does
        check("R6 held no rerequest", {7'b0, int_req}, 8'h00);
        set_irq(8'h00);
        set_irq(8'h02);
        check("R6 new edge", {7'b0, int_req}, 8'h01);
        set_irq(8'h00);
        rd_sel(1'b0, v); check("R6 drop clears", v, 8'h00);

        // R5: masked input latched but silent
        wr(1'b1, 8'h08);
        rd_mask(v); check("R5 mask read", v, 8'h08);
        set_irq(8'h08);
        check("R5 masked silent", {7'b0, int_req}, 8'h00);
        rd_sel(1'b0, v); check("R6 IRR latched", v, 8'h08);
        set_irq(8'h00);

        // R9: spurious acknowledge with input 7 masked
        wr(1'b1, 8'h80);
        set_irq(8'h08);
        irq_in = 8'h00; @(negedge clk);
        check("R9 request gone", {7'b0, int_req}, 8'h00);
        pulse_ack();
        check("R9 vector", vector, 8'h27);
        rd_sel(1'b1, v); check("R9 ISR unchanged", v, 8'h00);
        wr(1'b1, 8'h00);

        // R14: setup word clears in-service and selects IRR
        set_irq(8'h10); pulse_ack(); set_irq(8'h00);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h03);
        a0 = 1'b0; #1; check("R14 IRR selected", rd_data, 8'h00);
        rd_sel(1'b1, v); check("R14 ISR cleared", v, 8'h00);
        check("R3 slave id", cascade_cfg, 8'h02);

        // R13: automatic release
        set_irq(8'h10);
        pulse_ack();
        check("R13 vector", vector, 8'h44);
        rd_sel(1'b1, v); check("R13 no ISR", v, 8'h00);
        set_irq(8'h00);

        // R2/R4: single mode, no fourth word
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h08);
        check("R2 single ready", {7'b0, ready}, 8'h01);
        check("R3 cascade kept", cascade_cfg, 8'h02);
        set_irq(8'h01);
        pulse_ack();
        check("R2 single vector", vector, 8'h08);
        rd_sel(1'b1, v); check("R4 normal EOI default", v, 8'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule